// File: doc/BRIEF.md
# Quadrature Encoder Counter

This block turns two quadrature signals from a rotary or linear encoder into a position count. Each input passes through a two-flop synchronizer. Each input can be inverted. An edge detector then follows. A 3-bit mode input chooses what advances the counter:

- edges of channel B only (two counts per quadrature cycle),
- edges of channel A only,
- edges of both channels (four counts per cycle),
- or a free-running internal tick from a fixed clock divider.

On an encoder edge, the level of the opposite channel sets the direction of the count.

The counter runs between 0 and a reload value given at an input, and wraps at either end. A wrap in either direction raises a one-cycle update pulse. This pulse can drive a periodic trigger or extend the count in software. A direction flag records the sense of the most recent count. If both channels change in the same cycle, the edge pair is an illegal quadrature step and is discarded.

Top module: `qenc_counter`

## Requirements
- R1: After reset, count_o is 0, down_o is 0 and update_o is 0.
- R2: With mode_i = 1, only edges of channel B count. A rising B edge counts up when A is high and down when A is low; a falling B edge does the opposite. Edges of channel A leave count_o and down_o unchanged.
- R3: With mode_i = 2, only edges of channel A count. A rising A edge counts up when B is low and down when B is high; a falling A edge does the opposite. Edges of channel B are ignored.
- R4: With mode_i = 3, edges of both channels count, each under the direction rule of R2 or R3. The Gray order A,B = 00, 10, 11, 01 is the upward sequence.
- R5: In modes 1 to 3, a cycle in which both synchronized channels change at once changes neither count_o nor down_o, and raises no update pulse.
- R6: An up count from a value greater than or equal to reload_i gives 0, and update_o is high for exactly that one cycle.
- R7: A down count from 0 gives reload_i, and update_o is high for exactly that one cycle. update_o is low in every cycle without a wrap.
- R8: down_o becomes 1 after a down count and 0 after an up count. It holds its value in every cycle without a count.
- R9: A change on ti_a_i or ti_b_i reaches count_o at the third rising clock edge after it is applied, and not before.
- R10: When inv_a_i or inv_b_i is high, the matching input is complemented before synchronization, so both its edge sense and its level are reversed.
- R11: With mode_i = 0, count_o increments once every PRESC clock cycles, with the first increment PRESC cycles after mode 0 is entered. Encoder edges are ignored in this mode.
- R12: With mode_i from 4 to 7, count_o and down_o hold, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Count source: 0 internal tick, 1 B edges, 2 A edges, 3 both, 4-7 hold |
| inv_a_i | input | 1 | Invert channel A |
| inv_b_i | input | 1 | Invert channel B |
| ti_a_i | input | 1 | Encoder channel A, asynchronous |
| ti_b_i | input | 1 | Encoder channel B, asynchronous |
| reload_i | input | CNT_W | Upper bound of the count range |
| count_o | output | CNT_W | Current count |
| down_o | output | 1 | 1 if the last count went down |
| update_o | output | 1 | One-cycle pulse on a wrap in either direction |

## Verification
A count step and a wrap can fall in the same cycle. When they do, the counter must load 0 or the reload value rather than step by one, and it must pulse update_o.

The bench provokes this in several ways:
- up and down quadrature sequences that reach both ends of the range,
- a free-running internal-tick run that passes the top of the range,
- a lowered reload_i that leaves the count above the new bound, so the next up edge must wrap at once.

A scoreboard holds the count, direction and pulse expected in each of these cycles. It also flags an update pulse in any cycle where no wrap was predicted.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;

  typedef enum logic [2:0] {
    SM_INTCLK  = 3'd0,
    SM_EDGE_B  = 3'd1,
    SM_EDGE_A  = 3'd2,
    SM_EDGE_AB = 3'd3
  } slave_mode_e;

  // Direction for an edge on channel A, given A's new level and B's level.
  // Returns 1 for a down count.
  function automatic logic a_edge_down(input logic a_now, input logic b_lvl);
    return ~(a_now ^ b_lvl);
  endfunction

  // Direction for an edge on channel B, given B's new level and A's level.
  function automatic logic b_edge_down(input logic b_now, input logic a_lvl);
    return b_now ^ a_lvl;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
`timescale 1ns/1ps
module qenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic inv_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      prev_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], raw_i ^ inv_i};
      prev_q <= shreg[STAGES-1];
    end
  end

  assign level_o = shreg[STAGES-1];
  assign edge_o  = shreg[STAGES-1] ^ prev_q;
endmodule

// File: rtl/qenc_presc.sv
`timescale 1ns/1ps
module qenc_presc #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (!run_i)     div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (div_q == LAST);

  // R11: ticks of the internal source are never adjacent
  a_r11_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/qenc_decode.sv
`timescale 1ns/1ps
module qenc_decode
  import qenc_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       lvl_a_i,
  input  logic       lvl_b_i,
  input  logic       edge_a_i,
  input  logic       edge_b_i,
  input  logic       tick_i,
  output logic       step_o,
  output logic       down_o
);
  logic dn_a, dn_b;

  assign dn_a = a_edge_down(lvl_a_i, lvl_b_i);
  assign dn_b = b_edge_down(lvl_b_i, lvl_a_i);

  always_comb begin
    step_o = 1'b0;
    down_o = 1'b0;
    case (slave_mode_e'(mode_i))
      SM_INTCLK:  begin step_o = tick_i;               down_o = 1'b0; end
      SM_EDGE_B:  begin step_o = edge_b_i & ~edge_a_i; down_o = dn_b; end
      SM_EDGE_A:  begin step_o = edge_a_i & ~edge_b_i; down_o = dn_a; end
      SM_EDGE_AB: begin
        step_o = edge_a_i ^ edge_b_i;
        down_o = edge_a_i ? dn_a : dn_b;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qenc_count.sv
`timescale 1ns/1ps
module qenc_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             down_o,
  output logic             update_o
);
  function automatic logic [CNT_W-1:0] next_val(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] rel,
                                                input logic dn);
    if (dn) return (cur == '0) ? rel : cur - 1'b1;
    else    return (cur >= rel) ? '0 : cur + 1'b1;
  endfunction

  logic wrap;
  assign wrap = step_i && (down_i ? (count_o == '0) : (count_o >= reload_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o  <= '0;
      down_o   <= 1'b0;
      update_o <= 1'b0;
    end else begin
      update_o <= wrap;
      if (step_i) begin
        count_o <= next_val(count_o, reload_i, down_i);
        down_o  <= down_i;
      end
    end
  end

  // R8: without a count the state holds and no pulse appears
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(count_o) && $stable(down_o) && !update_o));

  // R7: an update pulse lands on one end of the range
  a_r7_update_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> (count_o == '0 || count_o == $past(reload_i)));

  // R2: outside a wrap the count moves by at most one
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_o && count_o != $past(count_o)) |->
      (count_o == $past(count_o) + 1'b1 || count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/qenc_counter.sv
`timescale 1ns/1ps
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             ti_a_i,
  input  logic             ti_b_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             down_o,
  output logic             update_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw, inv, lvl, edg;
  logic           tick, step, step_dn, enc_mode;

  assign raw = {ti_b_i, ti_a_i};
  assign inv = {inv_b_i, inv_a_i};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    qenc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw[g]),
      .inv_i   (inv[g]),
      .level_o (lvl[g]),
      .edge_o  (edg[g])
    );
  end

  qenc_presc #(.DIV(PRESC)) i_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (mode_i == SM_INTCLK),
    .tick_o (tick)
  );

  qenc_decode i_decode (
    .mode_i   (mode_i),
    .lvl_a_i  (lvl[0]),
    .lvl_b_i  (lvl[1]),
    .edge_a_i (edg[0]),
    .edge_b_i (edg[1]),
    .tick_i   (tick),
    .step_o   (step),
    .down_o   (step_dn)
  );

  qenc_count #(.CNT_W(CNT_W)) i_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step),
    .down_i   (step_dn),
    .reload_i (reload_i),
    .count_o  (count_o),
    .down_o   (down_o),
    .update_o (update_o)
  );

  assign enc_mode = (mode_i == SM_EDGE_A) || (mode_i == SM_EDGE_B) || (mode_i == SM_EDGE_AB);

  // R5: a simultaneous edge pair is discarded
  a_r5_pair_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_mode && edg[0] && edg[1]) |=> ($stable(count_o) && !update_o));

  // R12: reserved mode codes freeze the counter
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i >= 3'd4) |=> ($stable(count_o) && $stable(down_o)));
endmodule

// File: tb/test_qenc_counter.sv
`timescale 1ns/1ps
module test_qenc_counter;
  localparam int W = 16;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] mode;
  logic inv_a, inv_b, a, b;
  logic [W-1:0] reload;
  logic [W-1:0] count;
  logic down, upd;

  always #2.5 clk = ~clk;

  qenc_counter #(.CNT_W(W), .PRESC(P), .SYNC_STAGES(2)) i_qenc_counter (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .inv_a_i(inv_a), .inv_b_i(inv_b),
    .ti_a_i(a), .ti_b_i(b), .reload_i(reload),
    .count_o(count), .down_o(down), .update_o(upd)
  );

  typedef struct {
    int           due;
    logic [W-1:0] cnt;
    logic         dn;
    logic         up;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   started = 0;
  logic [W-1:0] m_cnt;
  logic m_dn;
  logic pa, pb;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int gidx(input logic x, input logic y);
    case ({x, y})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic push(input int due, input logic wrapped, input string tag);
    exp_t e;
    e.due = due; e.cnt = m_cnt; e.dn = m_dn; e.up = wrapped; e.tag = tag;
    q.push_back(e);
  endtask

  // Advance the model by one count; returns 1 on a wrap.
  function automatic logic model_step(input logic dn);
    logic w;
    if (dn) begin w = (m_cnt == 0);       m_cnt = w ? reload : m_cnt - 1'b1; end
    else    begin w = (m_cnt >= reload);  m_cnt = w ? '0 : m_cnt + 1'b1; end
    m_dn = dn;
    return w;
  endfunction

  task automatic drive(input logic na, input logic nb, input logic ia, input logic ib,
                       input string tag);
    logic ea, eb, ca, cb, st, w, dn;
    @(negedge clk);
    a = na; b = nb; inv_a = ia; inv_b = ib;
    ea = na ^ ia; eb = nb ^ ib;
    ca = (ea != pa); cb = (eb != pb);
    case (mode)
      3'd1:    st = cb & ~ca;
      3'd2:    st = ca & ~cb;
      3'd3:    st = ca ^ cb;
      default: st = 1'b0;
    endcase
    // R9: one cycle early nothing has moved yet
    push(cyc + 2, 1'b0, "R9");
    w = 1'b0;
    if (st) begin
      dn = !(((gidx(pa, pb) + 1) % 4) == gidx(ea, eb));
      w  = model_step(dn);
    end
    push(cyc + 3, w, tag);
    pa = ea; pb = eb;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
  endtask

  // R11: internal tick source, with an encoder edge thrown in that must be ignored
  task automatic run_internal(input int ticks);
    int c;
    logic w;
    @(negedge clk);
    mode = 3'd0;
    c = cyc;
    for (int k = 1; k <= ticks; k++) begin
      w = model_step(1'b0);
      push(c + k * P, w, (w ? "R6" : "R11"));
    end
    while (cyc != c + P + 1) @(negedge clk);
    a = ~a; pa = a ^ inv_a;
    while (cyc != c + ticks * P) @(negedge clk);
    mode = 3'd5;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        n_chk++;
        if (count !== q[0].cnt || down !== q[0].dn || upd !== q[0].up) begin
          n_bad++;
          $display("FAIL %s cyc=%0d: actual cnt=%0d dn=%0b upd=%0b expected cnt=%0d dn=%0b upd=%0b",
                   q[0].tag, cyc, count, down, upd, q[0].cnt, q[0].dn, q[0].up);
        end
        void'(q.pop_front());
      end else if (upd !== 1'b0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R7 cyc=%0d: actual upd=%0b expected upd=0", cyc, upd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 3'd3; inv_a = 0; inv_b = 0; a = 0; b = 0; reload = 16'd5;
    m_cnt = '0; m_dn = 1'b0; pa = 0; pb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (count !== '0 || down !== 1'b0 || upd !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: actual cnt=%0d dn=%0b upd=%0b expected cnt=0 dn=0 upd=0", count, down, upd);
    end
    started = 1;

    // x4 mode: climb to the top, wrap, wrap back down
    drive(1, 0, 0, 0, "R4");
    drive(1, 1, 0, 0, "R4");
    drive(0, 1, 0, 0, "R8");
    drive(0, 0, 0, 0, "R4");
    drive(1, 0, 0, 0, "R4");
    drive(1, 1, 0, 0, "R6");
    drive(1, 0, 0, 0, "R7");
    drive(0, 0, 0, 0, "R8");
    drive(1, 1, 0, 0, "R5");
    drive(0, 0, 0, 0, "R5");

    // B edges only
    set_mode(3'd1);
    drive(1, 0, 0, 0, "R2");
    drive(1, 1, 0, 0, "R2");
    drive(1, 0, 0, 0, "R2");
    drive(0, 0, 0, 0, "R2");

    // A edges only
    set_mode(3'd2);
    drive(0, 1, 0, 0, "R3");
    drive(1, 1, 0, 0, "R3");
    drive(0, 1, 0, 0, "R3");
    drive(0, 0, 0, 0, "R3");

    // reserved code holds
    set_mode(3'd5);
    drive(1, 0, 0, 0, "R12");
    drive(1, 1, 0, 0, "R12");
    drive(1, 1, 1, 0, "R12");

    // inverted channel A
    set_mode(3'd3);
    drive(0, 1, 1, 0, "R10");
    drive(1, 1, 1, 0, "R10");

    // internal tick, passes the top of the range
    run_internal(3);

    // lowered reload leaves the count above the bound
    @(negedge clk); reload = 16'd2;
    set_mode(3'd3);
    drive(1, 1, 1, 0, "R4");
    drive(1, 0, 1, 0, "R6");
    drive(0, 0, 1, 0, "R4");
    drive(0, 1, 1, 0, "R4");
    @(negedge clk); reload = 16'd1;
    drive(1, 1, 1, 0, "R6");

    while (q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule